// File: doc/BRIEF.md
# Tunnelled Half-Duplex Debug Data Register

This block is one data register on the JTAG side of a debug port. It carries a byte-wide, half-duplex debug link over the ordinary TAP data path. Each DR scan moves exactly one frame of nine bits. A frame holds eight data bits followed by one parity bit, and it travels in only one direction per scan. The TAP controller supplies three state strobes: capture, shift and update. The block runs entirely from TCK. The debug controller on the other side sees three things: a transmit slot (byte, kind, request, acknowledge), a receive port (byte, one-cycle valid, parity-error flag, decoded character kind) and a mode input that selects transmit or receive.

When there is nothing valid to send, capture loads a reserved filler character whose parity bit is deliberately wrong. The far end therefore sees a parity-error frame and can tell it apart from data. Two more reserved characters, BREAK and DELAY, can be sent in the same way, and all three are recognised on reception.

Top module: `jtag_tunnel_dr`

## Requirements
- R1: While `trst_n` is low, and at once when it falls, the block holds these values: `tdo` 0, `tx_ack` 0, `rx_valid` 0, `rx_perr` 0, `rx_data` 0, `rx_kind` 0. The transmit slot is empty.
- R2: In transmit mode (`rx_mode`=0), a capture edge with a byte waiting loads that byte with even parity. Even parity means the XOR of all nine frame bits is 0. `tx_ack` is 1 for exactly the one cycle after that edge, and the slot becomes empty.
- R3: A capture edge in receive mode, or in transmit mode with the slot empty, loads the filler 0xEB with its parity bit set to 1.
- R4: Each shift edge moves the frame one place toward TDO and takes `tdi` in at the far end. The data LSB leaves first and the parity bit leaves ninth. After nine shifts, the register holds the nine TDI bits in arrival order.
- R5: `tdo` changes only on falling TCK edges. It shows the bit at the output end of the frame as it stands after the preceding rising edge.
- R6: `tx_kind` selects what a transmit request sends: 00 sends the byte with correct parity; 01 sends 0xBB, 10 sends 0xDB and 11 sends 0xEB, each with the parity bit inverted from the even value.
- R7: An update edge in receive mode puts the first eight received bits on `rx_data` (first bit = LSB). It pulses `rx_valid` for the one cycle after that edge.
- R8: At each receive update, `rx_perr` becomes 1 if the XOR of the nine received bits is 1, and 0 otherwise. Between updates it holds its value.
- R9: At each receive update, `rx_kind` becomes 11 (0xEB), 01 (0xBB) or 10 (0xDB) when the frame has a parity error and its byte matches that code. In every other case it becomes 00.
- R10: A `tx_req` is taken only while the slot is empty. A request taken at or after a capture edge waits for the next capture. A request made while a byte is waiting is ignored.
- R11: An update edge in transmit mode leaves `rx_valid` low and `rx_data`, `rx_perr` and `rx_kind` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all timing derives from it |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| capture_dr | input | 1 | TAP is in capture for this register |
| shift_dr | input | 1 | TAP is in shift for this register |
| update_dr | input | 1 | TAP is in update for this register |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| rx_mode | input | 1 | 1 = receive direction, 0 = transmit direction |
| tx_data | input | 8 | Byte to send |
| tx_kind | input | 2 | 00 data, 01 BREAK, 10 DELAY, 11 EMPTY |
| tx_req | input | 1 | Offer `tx_data`/`tx_kind` to the slot |
| tx_ack | output | 1 | Waiting byte was loaded at the last capture |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse after a receive update |
| rx_perr | output | 1 | Parity error in the last received frame |
| rx_kind | output | 2 | Decoded reserved character of the last frame |

## Verification
The hardest case to reach is a request that lands in the middle of a scan, or in the very cycle of a capture edge, and is followed by a second request. Only the order of scans can then show which byte was kept. The bench pulses `tx_req` at chosen positions inside a scan and then runs further scans. It checks that the first byte appears one scan later, that the extra request left no trace, and that the scan after that falls back to the filler. A received 0xBB with correct parity is also sent, to show that reserved codes are recognised only when the parity is wrong.

// File: rtl/jtd_pkg.sv
package jtd_pkg;

    typedef enum logic [1:0] {
        CHR_DATA  = 2'b00,
        CHR_BREAK = 2'b01,
        CHR_DELAY = 2'b10,
        CHR_EMPTY = 2'b11
    } chr_kind_e;

endpackage

// File: rtl/jtd_frame_src.sv
module jtd_frame_src
    import jtd_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter logic [DATA_W-1:0] EMPTY_CODE = 'hEB,
    parameter logic [DATA_W-1:0] BREAK_CODE = 'hBB,
    parameter logic [DATA_W-1:0] DELAY_CODE = 'hDB
) (
    input  logic              rx_mode,
    input  logic              pend,
    input  logic [DATA_W-1:0] pend_data,
    input  chr_kind_e         pend_kind,
    output logic [DATA_W:0]   frame,
    output logic              take
);

    chr_kind_e         sel_kind;
    logic [DATA_W-1:0] sel_byte;
    logic              even_par;

    always_comb begin
        take     = pend && !rx_mode;
        sel_kind = take ? pend_kind : CHR_EMPTY;
        unique case (sel_kind)
            CHR_DATA:  sel_byte = pend_data;
            CHR_BREAK: sel_byte = BREAK_CODE;
            CHR_DELAY: sel_byte = DELAY_CODE;
            default:   sel_byte = EMPTY_CODE;
        endcase
        even_par = ^sel_byte;
        // reserved characters go out with the wrong parity on purpose
        frame = {(sel_kind == CHR_DATA) ? even_par : ~even_par, sel_byte};
    end

endmodule

// File: rtl/jtd_rx_decode.sv
module jtd_rx_decode
    import jtd_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter logic [DATA_W-1:0] EMPTY_CODE = 'hEB,
    parameter logic [DATA_W-1:0] BREAK_CODE = 'hBB,
    parameter logic [DATA_W-1:0] DELAY_CODE = 'hDB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [DATA_W:0]   frame,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              perr,
    output chr_kind_e         kind
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              perr;
        chr_kind_e         kind;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   bad_par;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        bad_par    = ^frame;
        if (upd_en) begin
            st_d.data  = frame[DATA_W-1:0];
            st_d.valid = 1'b1;
            st_d.perr  = bad_par;
            st_d.kind  = CHR_DATA;
            if (bad_par) begin
                if (frame[DATA_W-1:0] == EMPTY_CODE)      st_d.kind = CHR_EMPTY;
                else if (frame[DATA_W-1:0] == BREAK_CODE) st_d.kind = CHR_BREAK;
                else if (frame[DATA_W-1:0] == DELAY_CODE) st_d.kind = CHR_DELAY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign perr  = st_q.perr;
    assign kind  = st_q.kind;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R7: a valid pulse only follows a receive update
    a_r7_valid_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && valid |-> $past(upd_en));

    // R8: the error flag moves only together with a valid pulse
    a_r8_perr_held: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !valid |-> $stable(perr));

    // R9: a reserved kind is never reported on a frame with good parity
    a_r9_kind_needs_perr: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CHR_DATA) |-> perr);

endmodule

// File: rtl/jtd_tdo_stage.sv
module jtd_tdo_stage (
    input  logic tck,
    input  logic trst_n,
    input  logic bit_in,
    output logic tdo
);

    logic tdo_d, tdo_q;

    always_comb tdo_d = bit_in;

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo = tdo_q;

endmodule

// File: rtl/jtag_tunnel_dr.sv
module jtag_tunnel_dr
    import jtd_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter logic [DATA_W-1:0] EMPTY_CODE = 'hEB,
    parameter logic [DATA_W-1:0] BREAK_CODE = 'hBB,
    parameter logic [DATA_W-1:0] DELAY_CODE = 'hDB
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              rx_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [1:0]        tx_kind,
    input  logic              tx_req,
    output logic              tx_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic [1:0]        rx_kind
);

    localparam int FRAME_W = DATA_W + 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               pend;
        logic [DATA_W-1:0]  pdata;
        chr_kind_e          pkind;
        logic               ack;
    } dr_st_t;

    dr_st_t             st_d, st_q;
    logic [FRAME_W-1:0] load_frame;
    logic               load_take;
    logic               upd_en;
    chr_kind_e          rx_kind_e;

    jtd_frame_src #(
        .DATA_W(DATA_W), .EMPTY_CODE(EMPTY_CODE),
        .BREAK_CODE(BREAK_CODE), .DELAY_CODE(DELAY_CODE)
    ) u_src (
        .rx_mode   (rx_mode),
        .pend      (st_q.pend),
        .pend_data (st_q.pdata),
        .pend_kind (st_q.pkind),
        .frame     (load_frame),
        .take      (load_take)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (capture_dr) begin
            st_d.sr = load_frame;
            if (load_take) begin
                st_d.ack  = 1'b1;
                st_d.pend = 1'b0;
            end
        end else if (shift_dr) begin
            st_d.sr = {tdi, st_q.sr[FRAME_W-1:1]};
        end
        // slot accepts only when empty before this edge
        if (tx_req && !st_q.pend) begin
            st_d.pend  = 1'b1;
            st_d.pdata = tx_data;
            st_d.pkind = chr_kind_e'(tx_kind);
        end
        upd_en = update_dr && rx_mode && !capture_dr && !shift_dr;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    jtd_rx_decode #(
        .DATA_W(DATA_W), .EMPTY_CODE(EMPTY_CODE),
        .BREAK_CODE(BREAK_CODE), .DELAY_CODE(DELAY_CODE)
    ) u_rx (
        .clk    (tck),
        .rst_n  (trst_n),
        .upd_en (upd_en),
        .frame  (st_q.sr),
        .data   (rx_data),
        .valid  (rx_valid),
        .perr   (rx_perr),
        .kind   (rx_kind_e)
    );

    jtd_tdo_stage u_tdo (
        .tck    (tck),
        .trst_n (trst_n),
        .bit_in (st_q.sr[0]),
        .tdo    (tdo)
    );

    assign tx_ack  = st_q.ack;
    assign rx_kind = rx_kind_e;

    logic seen_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    // R2: acknowledging a load leaves the slot empty
    a_r2_ack_empties_slot: assert property (@(posedge tck) disable iff (!trst_n)
        tx_ack |-> !st_q.pend);

    // R3: a capture without a byte to send yields the filler with parity set
    a_r3_filler_loaded: assert property (@(posedge tck) disable iff (!trst_n)
        seen_q && $past(capture_dr && (rx_mode || !st_q.pend))
        |-> st_q.sr == {1'b1, EMPTY_CODE});

    // R4: one shift moves the frame one place and takes in TDI
    a_r4_shift_moves: assert property (@(posedge tck) disable iff (!trst_n)
        seen_q && $past(shift_dr && !capture_dr)
        |-> st_q.sr[FRAME_W-2:0] == $past(st_q.sr[FRAME_W-1:1]) && st_q.sr[FRAME_W-1] == $past(tdi));

    // R5: between rising edges TDO shows the output end of the frame
    a_r5_tdo_tracks: assert property (@(posedge tck) disable iff (!trst_n)
        seen_q |-> tdo == st_q.sr[0]);

    // R10: a waiting byte survives until a transmit capture takes it
    a_r10_pending_held: assert property (@(posedge tck) disable iff (!trst_n)
        seen_q && $past(st_q.pend && !(capture_dr && !rx_mode))
        |-> st_q.pend && st_q.pdata == $past(st_q.pdata));

endmodule

// File: tb/jtag_tunnel_dr_bench.sv
module jtag_tunnel_dr_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b1;
    logic       cap = 0, sh = 0, up = 0, tdi = 0;
    logic       rxm = 0, req = 0;
    logic [7:0] txd = 0;
    logic [1:0] txk = 0;
    logic       tdo, tx_ack, rx_valid, rx_perr;
    logic [7:0] rx_data;
    logic [1:0] rx_kind;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    jtag_tunnel_dr u_jtag_tunnel_dr (
        .tck(tck), .trst_n(trst_n), .capture_dr(cap), .shift_dr(sh), .update_dr(up),
        .tdi(tdi), .tdo(tdo), .rx_mode(rxm), .tx_data(txd), .tx_kind(txk),
        .tx_req(req), .tx_ack(tx_ack), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_kind(rx_kind)
    );

    always #5 tck = ~tck;

    // behavioural reference model
    bit       mq[$];
    bit       m_pend, m_ack, m_rxv, m_perr;
    bit [7:0] m_pdata, m_rxd;
    bit [1:0] m_pkind, m_rkind;

    function automatic int ones8(bit [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) n += b[i];
        return n;
    endfunction

    function automatic bit [7:0] code_of(bit [1:0] k, bit [7:0] d);
        case (k)
            2'd1: return 8'hBB;
            2'd2: return 8'hDB;
            2'd3: return 8'hEB;
            default: return d;
        endcase
    endfunction

    task automatic model_reset();
        mq.delete();
        for (int i = 0; i < 9; i++) mq.push_back(1'b0);
        m_pend = 0; m_ack = 0; m_rxv = 0; m_perr = 0;
        m_pdata = 0; m_rxd = 0; m_pkind = 0; m_rkind = 0;
    endtask

    task automatic model_edge();
        bit old_pend = m_pend;
        bit take = cap && !rxm && old_pend;
        m_rxv = 0;
        if (cap) begin
            bit [1:0] k = take ? m_pkind : 2'd3;
            bit [7:0] b = code_of(k, m_pdata);
            bit p = ones8(b) % 2;
            if (k != 2'd0) p = !p;
            mq.delete();
            for (int i = 0; i < 8; i++) mq.push_back(b[i]);
            mq.push_back(p);
        end else if (sh) begin
            void'(mq.pop_front());
            mq.push_back(tdi);
        end else if (up && rxm) begin
            int n = 0;
            for (int i = 0; i < 8; i++) m_rxd[i] = mq[i];
            for (int i = 0; i < 9; i++) n += mq[i];
            m_rxv = 1;
            m_perr = n % 2;
            m_rkind = 2'd0;
            if (m_perr) begin
                if (m_rxd == 8'hEB) m_rkind = 2'd3;
                else if (m_rxd == 8'hBB) m_rkind = 2'd1;
                else if (m_rxd == 8'hDB) m_rkind = 2'd2;
            end
        end
        m_ack = take;
        if (take) m_pend = 0;
        else if (req && !old_pend) begin
            m_pend = 1; m_pdata = txd; m_pkind = txk;
        end
    endtask

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_regs();
        chk("tx_ack (R2)", tx_ack, m_ack);
        chk("rx_valid (R7)", rx_valid, m_rxv);
        chk("rx_data (R7)", rx_data, m_rxd);
        chk("rx_perr (R8)", rx_perr, m_perr);
        chk("rx_kind (R9)", rx_kind, m_rkind);
    endtask

    // one TCK cycle: inputs are set after a falling edge
    task automatic step(bit c, bit s, bit u, bit t, bit r);
        cap = c; sh = s; up = u; tdi = t; req = r;
        @(posedge tck);
        model_edge();
        #1;
        req = 0;
        chk_regs();
        @(negedge tck);
        #1;
        chk("tdo (R4/R5)", tdo, mq[0]);
    endtask

    // full scan; the request pulses at position req_at (0 = capture, 10 = update)
    task automatic scan(bit [8:0] shin, int req_at);
        step(1, 0, 0, 0, req_at == 0);
        for (int i = 0; i < 9; i++) step(0, 1, 0, shin[i], req_at == i + 1);
        step(0, 0, 1, 0, req_at == 10);
        step(0, 0, 0, 0, 0);
    endtask

    task automatic offer(bit [7:0] d, bit [1:0] k);
        txd = d; txk = k;
        step(0, 0, 0, 0, 1);
    endtask

    function automatic bit [8:0] good(bit [7:0] b);
        return {1'(ones8(b) % 2), b};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        #3 trst_n = 0;
        #1;
        tag = "R1";
        chk("tdo", tdo, 0); chk("tx_ack", tx_ack, 0); chk("rx_valid", rx_valid, 0);
        chk("rx_perr", rx_perr, 0); chk("rx_data", rx_data, 0); chk("rx_kind", rx_kind, 0);
        @(negedge tck); #1 trst_n = 1;
        step(0, 0, 0, 0, 0);

        // R3: filler in transmit mode with an empty slot, and in receive mode
        tag = "R3"; rxm = 0; scan(9'h0, -1);
        rxm = 1; scan(9'h1FF, -1);

        // R7/R8: receive bytes with correct and wrong parity
        tag = "R8"; rxm = 1;
        scan(good(8'h3C), -1);
        scan(good(8'h81) ^ 9'h100, -1);
        scan(good(8'h00), -1);
        // R9: reserved characters, wrong parity and then correct parity
        tag = "R9";
        scan({1'b1, 8'hEB}, -1); scan({1'b1, 8'hBB}, -1);
        scan({1'b1, 8'hDB}, -1); scan({1'b0, 8'hBB}, -1);

        // R2: transmit data bytes with even parity
        tag = "R2"; rxm = 0;
        offer(8'hA5, 0); scan(9'h155, -1);
        offer(8'h00, 0); scan(9'h0AA, -1);
        offer(8'hFF, 0); scan(9'h1FF, -1);
        // R6: reserved characters sent with inverted parity
        tag = "R6";
        offer(8'h12, 1); scan(9'h0, -1);
        offer(8'h34, 2); scan(9'h0, -1);
        offer(8'h56, 3); scan(9'h0, -1);

        // R10: request mid-scan waits; extra requests are ignored
        tag = "R10"; txd = 8'h5A; txk = 0;
        scan(9'h0, 4);
        txd = 8'hC3;
        scan(9'h0, 2);
        scan(9'h0, -1);
        txd = 8'h77; scan(9'h0, 0);
        scan(9'h0, -1);

        // R11: transmit-mode update leaves receive outputs alone
        tag = "R11"; rxm = 0;
        scan(good(8'h99), -1);
        step(0, 0, 1, 0, 0);

        // mixed traffic
        tag = "R4";
        for (int n = 0; n < 40; n++) begin
            rxm = $urandom_range(0, 1);
            txd = $urandom; txk = $urandom;
            scan($urandom, $urandom_range(0, 14));
        end

        // R1: asynchronous reset in the middle of a scan
        tag = "R1"; rxm = 0;
        offer(8'h3E, 0);
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 1, 0);
        #2 trst_n = 0; model_reset();
        #1;
        chk("tdo", tdo, 0); chk("tx_ack", tx_ack, 0); chk("rx_valid", rx_valid, 0);
        chk("rx_perr", rx_perr, 0); chk("rx_kind", rx_kind, 0);
        @(negedge tck); #1 trst_n = 1;
        scan(9'h0, -1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule